// File: doc/BRIEF.md
# Two-wire controller command decoder

This block sits behind the write-only command word of an I2C/SMBus controller. Each accepted 32-bit write is turned into two kinds of effect. The first kind updates long-lived mode state: host role, client role, high-speed, SMBus, packet error checking, alternative command handling, FIFO use and SCL rise boost. The second kind produces single-cycle action strobes that the serial engine, the FIFOs and the CRC logic consume.

Each mode has its own set bit and its own clear bit, so software never needs a read-modify-write. Some actions depend on live conditions. A role change waits for the transfer-complete status. A bus clear needs an enabled host and both bus lines high. A stop request is held until the engine reports that the current byte is finished.

All effects are registered. The mode outputs and strobes change on the clock edge that samples the write, and each strobe lasts exactly one cycle.

Top module: `tw_cmd_reg`

## Requirements
- R1: The write word is decoded with this bit map: 0 start, 1 stop, 2 host-set, 3 host-clear, 4 client-set, 5 client-clear, 6 quick, 7 soft reset, 8 HS-set, 9 HS-clear, 10 SMBus-set, 11 SMBus-clear, 12 PEC-set, 13 PEC-clear, 14 PEC request, 15 bus clear, 16 alt-command-set, 17 alt-command-clear, 19 SCL boost-set, 24 holding clear, 26 lock clear, 28 FIFO-set, 29 FIFO-clear. A 0 in any bit, and any write of all zeros, changes nothing.
- R2: While `wp_en_i` is 1, a write has no effect on any mode output or on any write-caused strobe.
- R3: For HS, SMBus, PEC, alternative command and FIFO, the clear bit wins over the set bit in the same word. The mode otherwise keeps its value. SCL boost is set-only and is cleared only by reset or soft reset.
- R4: Host and client are never enabled together. A set request takes effect only if its own clear bit is 0 and the other role's set request is absent. A request that would switch away from an active opposite role is dropped unless `txcomp_i` is 1. A role's clear bit always clears that role.
- R5: `bus_clear_o` pulses only if host mode was enabled before the write and both `sda_i` and `scl_i` are 1.
- R6: `quick_o` pulses only if host mode was enabled before the write.
- R7: The holding-clear bit pulses `thr_clr_o`, `txrdy_set_o` and `txcomp_set_o` together.
- R8: A soft-reset write pulses `soft_rst_o`. It clears all mode state and any pending stop, and every other bit of that word is ignored.
- R9: A written stop is held pending and `stop_o` pulses in the cycle after `byte_done_i`. `stop_o` also pulses after `nack_rx_i` is seen while host mode and `rd_mode_i` are both 1.
- R10: `start_o`, `pec_req_o` and `lock_clr_o` pulse for one cycle after each accepted write carrying their bit. Start and stop may be written in the same word.
- R11: After `rst_ni` is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | 32 | Command word |
| wp_en_i | input | 1 | Write protection active |
| sda_i | input | 1 | Sampled data line level |
| scl_i | input | 1 | Sampled clock line level |
| txcomp_i | input | 1 | Transfer-complete status |
| byte_done_i | input | 1 | Current byte finished on the bus |
| nack_rx_i | input | 1 | NACK received |
| rd_mode_i | input | 1 | Engine is in host read direction |
| host_en_o | output | 1 | Host role enabled |
| client_en_o | output | 1 | Client role enabled |
| hs_en_o | output | 1 | High-speed mode |
| smb_en_o | output | 1 | SMBus mode |
| pec_en_o | output | 1 | Packet error checking |
| acm_en_o | output | 1 | Alternative command mode |
| fifo_en_o | output | 1 | FIFOs enabled |
| sclrb_en_o | output | 1 | SCL rise boost |
| start_o | output | 1 | Start strobe |
| stop_o | output | 1 | Stop strobe |
| quick_o | output | 1 | Quick command strobe |
| bus_clear_o | output | 1 | Bus clear strobe |
| pec_req_o | output | 1 | PEC request strobe |
| soft_rst_o | output | 1 | Soft reset strobe |
| thr_clr_o | output | 1 | Holding register clear strobe |
| txrdy_set_o | output | 1 | Set transmit-ready flag |
| txcomp_set_o | output | 1 | Set transmit-complete flag |
| lock_clr_o | output | 1 | Lock clear strobe |

## Verification
The bench writes words where a set bit and its clear bit are both 1. A decoder with the wrong priority would leave the mode enabled. Role switches are attempted with transfer-complete both low and high. A design that ignores the gate would drop an active client mid-transfer or enable both roles at once. Bus clear and quick are issued before host mode exists and with either line low; a design without the gating would pulse them anyway. The bench also drives a stop written in the same cycle as `byte_done_i`, a NACK while a stop is already pending, and a soft reset mixed with every other bit. A wrong pending model would lose or double the stop, and a weak soft reset would let the other bits of that word through.

// File: rtl/tw_cmd_pkg.sv
package tw_cmd_pkg;
  localparam int CMD_W     = 32;
  localparam int B_START   = 0;
  localparam int B_STOP    = 1;
  localparam int B_HOST_S  = 2;
  localparam int B_HOST_C  = 3;
  localparam int B_CLI_S   = 4;
  localparam int B_CLI_C   = 5;
  localparam int B_QUICK   = 6;
  localparam int B_SRST    = 7;
  localparam int B_PECRQ   = 14;
  localparam int B_BCLR    = 15;
  localparam int B_BOOST   = 19;
  localparam int B_THRCLR  = 24;
  localparam int B_LOCKCLR = 26;
  // set/clear pairs: hs, smb, pec, acm, fifo
  localparam int N_PAIR = 5;
  localparam int PAIR_SET [N_PAIR] = '{8, 10, 12, 16, 28};
  localparam int PAIR_CLR [N_PAIR] = '{9, 11, 13, 17, 29};
endpackage

// File: rtl/tw_pair_flop.sv
module tw_pair_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic we_i,
  input  logic set_i,
  input  logic off_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q_o <= 1'b0;
    else if (clr_i)            q_o <= 1'b0;
    else if (we_i && off_i)    q_o <= 1'b0;
    else if (we_i && set_i)    q_o <= 1'b1;
  end
endmodule

// File: rtl/tw_role_ctl.sv
module tw_role_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic we_i,
  input  logic host_s_i,
  input  logic host_c_i,
  input  logic cli_s_i,
  input  logic cli_c_i,
  input  logic txcomp_i,
  output logic host_o,
  output logic client_o
);
  logic host_req, cli_req, clash, host_go, cli_go;

  assign host_req = host_s_i & ~host_c_i;
  assign cli_req  = cli_s_i & ~cli_c_i;
  assign clash    = host_req & cli_req;
  // a switch away from an active role waits for transfer complete
  assign host_go  = we_i & host_req & ~clash & (~client_o | txcomp_i);
  assign cli_go   = we_i & cli_req & ~clash & (~host_o | txcomp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_o   <= 1'b0;
      client_o <= 1'b0;
    end else if (clr_i) begin
      host_o   <= 1'b0;
      client_o <= 1'b0;
    end else begin
      if (we_i && host_c_i) host_o <= 1'b0;
      else if (host_go)     host_o <= 1'b1;
      else if (cli_go)      host_o <= 1'b0;
      if (we_i && cli_c_i)  client_o <= 1'b0;
      else if (cli_go)      client_o <= 1'b1;
      else if (host_go)     client_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_action_gen.sv
module tw_action_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic we_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic quick_i,
  input  logic bclr_i,
  input  logic pecrq_i,
  input  logic thrclr_i,
  input  logic lockclr_i,
  input  logic host_i,
  input  logic sda_i,
  input  logic scl_i,
  input  logic byte_done_i,
  input  logic nack_rx_i,
  input  logic rd_mode_i,
  output logic start_o,
  output logic stop_o,
  output logic quick_o,
  output logic bus_clear_o,
  output logic pec_req_o,
  output logic soft_rst_o,
  output logic thr_clr_o,
  output logic lock_clr_o
);
  logic stop_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_pend   <= 1'b0;
      start_o     <= 1'b0;
      stop_o      <= 1'b0;
      quick_o     <= 1'b0;
      bus_clear_o <= 1'b0;
      pec_req_o   <= 1'b0;
      soft_rst_o  <= 1'b0;
      thr_clr_o   <= 1'b0;
      lock_clr_o  <= 1'b0;
    end else begin
      soft_rst_o  <= clr_i;
      start_o     <= we_i & start_i;
      quick_o     <= we_i & quick_i & host_i;
      bus_clear_o <= we_i & bclr_i & host_i & sda_i & scl_i;
      pec_req_o   <= we_i & pecrq_i;
      thr_clr_o   <= we_i & thrclr_i;
      lock_clr_o  <= we_i & lockclr_i;
      if (clr_i) begin
        stop_pend <= 1'b0;
        stop_o    <= 1'b0;
      end else begin
        // a newly written stop waits for the next byte boundary
        stop_pend <= (stop_pend & ~byte_done_i) | (we_i & stop_i);
        stop_o    <= (stop_pend & byte_done_i) | (host_i & rd_mode_i & nack_rx_i);
      end
    end
  end
endmodule

// File: rtl/tw_cmd_reg.sv
module tw_cmd_reg
  import tw_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] wr_data_i,
  input  logic             wp_en_i,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic             txcomp_i,
  input  logic             byte_done_i,
  input  logic             nack_rx_i,
  input  logic             rd_mode_i,
  output logic             host_en_o,
  output logic             client_en_o,
  output logic             hs_en_o,
  output logic             smb_en_o,
  output logic             pec_en_o,
  output logic             acm_en_o,
  output logic             fifo_en_o,
  output logic             sclrb_en_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             quick_o,
  output logic             bus_clear_o,
  output logic             pec_req_o,
  output logic             soft_rst_o,
  output logic             thr_clr_o,
  output logic             txrdy_set_o,
  output logic             txcomp_set_o,
  output logic             lock_clr_o
);
  logic              acc, clr, we;
  logic [N_PAIR-1:0] pair_q;
  logic              unused_bits;

  assign acc = wr_en_i & ~wp_en_i;
  assign clr = acc & wr_data_i[B_SRST];
  assign we  = acc & ~wr_data_i[B_SRST];
  assign unused_bits = ^{wr_data_i[31:30], wr_data_i[27], wr_data_i[25],
                         wr_data_i[23:20], wr_data_i[18]};

  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    tw_pair_flop u_pair (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .we_i  (we),
      .set_i (wr_data_i[PAIR_SET[g]]),
      .off_i (wr_data_i[PAIR_CLR[g]]),
      .q_o   (pair_q[g])
    );
  end

  assign hs_en_o   = pair_q[0];
  assign smb_en_o  = pair_q[1];
  assign pec_en_o  = pair_q[2];
  assign acm_en_o  = pair_q[3];
  assign fifo_en_o = pair_q[4];

  // boost has no clear bit of its own
  tw_pair_flop u_boost (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .we_i  (we),
    .set_i (wr_data_i[B_BOOST]),
    .off_i (1'b0),
    .q_o   (sclrb_en_o)
  );

  tw_role_ctl u_role (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .we_i    (we),
    .host_s_i(wr_data_i[B_HOST_S]),
    .host_c_i(wr_data_i[B_HOST_C]),
    .cli_s_i (wr_data_i[B_CLI_S]),
    .cli_c_i (wr_data_i[B_CLI_C]),
    .txcomp_i(txcomp_i),
    .host_o  (host_en_o),
    .client_o(client_en_o)
  );

  tw_action_gen u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .we_i       (we),
    .start_i    (wr_data_i[B_START]),
    .stop_i     (wr_data_i[B_STOP]),
    .quick_i    (wr_data_i[B_QUICK]),
    .bclr_i     (wr_data_i[B_BCLR]),
    .pecrq_i    (wr_data_i[B_PECRQ]),
    .thrclr_i   (wr_data_i[B_THRCLR]),
    .lockclr_i  (wr_data_i[B_LOCKCLR]),
    .host_i     (host_en_o),
    .sda_i      (sda_i),
    .scl_i      (scl_i),
    .byte_done_i(byte_done_i),
    .nack_rx_i  (nack_rx_i),
    .rd_mode_i  (rd_mode_i),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .quick_o    (quick_o),
    .bus_clear_o(bus_clear_o),
    .pec_req_o  (pec_req_o),
    .soft_rst_o (soft_rst_o),
    .thr_clr_o  (thr_clr_o),
    .lock_clr_o (lock_clr_o)
  );

  assign txrdy_set_o  = thr_clr_o;
  assign txcomp_set_o = thr_clr_o;
endmodule

// File: rtl/tw_cmd_reg_chk.sv
module tw_cmd_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        wp_en_i,
  input logic        sda_i,
  input logic        scl_i,
  input logic        txcomp_i,
  input logic        byte_done_i,
  input logic        nack_rx_i,
  input logic        rd_mode_i,
  input logic        host_en_o,
  input logic        client_en_o,
  input logic        hs_en_o,
  input logic        smb_en_o,
  input logic        pec_en_o,
  input logic        acm_en_o,
  input logic        fifo_en_o,
  input logic        sclrb_en_o,
  input logic        start_o,
  input logic        stop_o,
  input logic        quick_o,
  input logic        bus_clear_o,
  input logic        pec_req_o,
  input logic        soft_rst_o,
  input logic        thr_clr_o,
  input logic        txrdy_set_o,
  input logic        txcomp_set_o,
  input logic        lock_clr_o
);
  logic [7:0] modes;
  assign modes = {host_en_o, client_en_o, hs_en_o, smb_en_o,
                  pec_en_o, acm_en_o, fifo_en_o, sclrb_en_o};

  assert_wp_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wp_en_i) |=> ($stable(modes) && !start_o && !quick_o &&
                             !bus_clear_o && !soft_rst_o && !thr_clr_o));

  assert_clear_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wp_en_i && wr_data_i[9] && wr_data_i[11]) |=> (!hs_en_o && !smb_en_o));

  assert_roles_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_en_o && client_en_o));

  assert_bus_clear_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clear_o |-> ($past(host_en_o) && $past(sda_i) && $past(scl_i)));

  assert_quick_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quick_o |-> $past(host_en_o));

  assert_flags_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_clr_o |-> (txrdy_set_o && txcomp_set_o));

  assert_srst_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (modes == 8'h00 && !stop_o && !start_o));

  assert_stop_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> ($past(byte_done_i) || $past(nack_rx_i)));
endmodule

bind tw_cmd_reg tw_cmd_reg_chk u_chk (.*);

// File: tb/tw_cmd_reg_bench.sv
module tw_cmd_reg_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, wp_en_i = 0, sda_i = 1, scl_i = 1, txcomp_i = 1;
  logic byte_done_i = 0, nack_rx_i = 0, rd_mode_i = 0;
  logic [31:0] wr_data_i = '0;
  logic host_en_o, client_en_o, hs_en_o, smb_en_o, pec_en_o, acm_en_o, fifo_en_o, sclrb_en_o;
  logic start_o, stop_o, quick_o, bus_clear_o, pec_req_o, soft_rst_o;
  logic thr_clr_o, txrdy_set_o, txcomp_set_o, lock_clr_o;

  int n_chk = 0, n_bad = 0;
  // model state
  logic e_host = 0, e_cli = 0, e_boost = 0, e_pend = 0;
  logic [4:0] e_pair = '0; // hs smb pec acm fifo
  logic e_start = 0, e_stop = 0, e_quick = 0, e_bclr = 0, e_pecrq = 0;
  logic e_srst = 0, e_thr = 0, e_lock = 0;

  always #4 clk_i = ~clk_i;

  tw_cmd_reg u_tw_cmd_reg (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 pairs"}, {3'b0, hs_en_o, smb_en_o, pec_en_o, acm_en_o, fifo_en_o}, {3'b0, e_pair});
    chk({tag, " R3 boost"}, {7'b0, sclrb_en_o}, {7'b0, e_boost});
    chk({tag, " R4 roles"}, {6'b0, host_en_o, client_en_o}, {6'b0, e_host, e_cli});
    chk({tag, " R5 bus clear"}, {7'b0, bus_clear_o}, {7'b0, e_bclr});
    chk({tag, " R6 quick"}, {7'b0, quick_o}, {7'b0, e_quick});
    chk({tag, " R7 holding clear"}, {5'b0, thr_clr_o, txrdy_set_o, txcomp_set_o}, {5'b0, {3{e_thr}}});
    chk({tag, " R8 soft reset"}, {7'b0, soft_rst_o}, {7'b0, e_srst});
    chk({tag, " R9 stop"}, {7'b0, stop_o}, {7'b0, e_stop});
    chk({tag, " R10 strobes"}, {5'b0, start_o, pec_req_o, lock_clr_o}, {5'b0, e_start, e_pecrq, e_lock});
  endtask

  // drive at a falling edge, predict, check at the next falling edge
  task automatic step(input string tag, input logic we, input logic [31:0] d, input logic wp,
                      input logic sda, input logic scl, input logic txc,
                      input logic bd, input logic nk, input logic rd);
    logic acc, sr, w, hreq, creq, clash, hgo, cgo, nh, nc;
    wr_en_i = we; wr_data_i = d; wp_en_i = wp; sda_i = sda; scl_i = scl;
    txcomp_i = txc; byte_done_i = bd; nack_rx_i = nk; rd_mode_i = rd;
    acc = we & ~wp; sr = acc & d[7]; w = acc & ~d[7];
    e_srst = sr;
    e_start = w & d[0];
    e_quick = w & d[6] & e_host;
    e_bclr = w & d[15] & e_host & sda & scl;
    e_pecrq = w & d[14];
    e_thr = w & d[24];
    e_lock = w & d[26];
    e_stop = sr ? 1'b0 : ((e_pend & bd) | (e_host & rd & nk));
    e_pend = sr ? 1'b0 : ((e_pend & ~bd) | (w & d[1]));
    hreq = d[2] & ~d[3]; creq = d[4] & ~d[5]; clash = hreq & creq;
    hgo = w & hreq & ~clash & (~e_cli | txc);
    cgo = w & creq & ~clash & (~e_host | txc);
    nh = (w & d[3]) ? 1'b0 : hgo ? 1'b1 : cgo ? 1'b0 : e_host;
    nc = (w & d[5]) ? 1'b0 : cgo ? 1'b1 : hgo ? 1'b0 : e_cli;
    e_host = sr ? 1'b0 : nh;
    e_cli  = sr ? 1'b0 : nc;
    e_pair[4] = sr ? 1'b0 : (w & d[9])  ? 1'b0 : (w & d[8])  ? 1'b1 : e_pair[4];
    e_pair[3] = sr ? 1'b0 : (w & d[11]) ? 1'b0 : (w & d[10]) ? 1'b1 : e_pair[3];
    e_pair[2] = sr ? 1'b0 : (w & d[13]) ? 1'b0 : (w & d[12]) ? 1'b1 : e_pair[2];
    e_pair[1] = sr ? 1'b0 : (w & d[17]) ? 1'b0 : (w & d[16]) ? 1'b1 : e_pair[1];
    e_pair[0] = sr ? 1'b0 : (w & d[29]) ? 1'b0 : (w & d[28]) ? 1'b1 : e_pair[0];
    e_boost = sr ? 1'b0 : (w & d[19]) ? 1'b1 : e_boost;
    @(posedge clk_i);
    @(negedge clk_i);
    check_all(tag);
  endtask

  task automatic wr(input string tag, input logic [31:0] d);
    step(tag, 1'b1, d, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R11 reset");
    wr("R1 zero word", 32'h0);
    wr("R5 bus clear before host", 32'h0000_8000);
    wr("R6 quick before host", 32'h0000_0040);
    wr("R1 set modes", 32'h1009_1504);               // host, hs, smb, pec, acm, boost, fifo
    wr("R3 clear wins", 32'h3003_3F00);              // all pairs set+clear
    step("R2 protected", 1'b1, 32'h0100_4155, 1'b1, 1, 1, 1, 0, 0, 0);
    step("R5 sda low", 1'b1, 32'h0000_8000, 1'b0, 0, 1, 1, 0, 0, 0);
    step("R5 scl low", 1'b1, 32'h0000_8000, 1'b0, 1, 0, 1, 0, 0, 0);
    wr("R5 bus clear ok", 32'h0000_8000);
    wr("R6 quick ok", 32'h0000_0040);
    wr("R7 holding clear", 32'h0100_0000);
    wr("R10 start stop", 32'h0000_0003);
    step("R9 byte done", 1'b0, 32'h0, 1'b0, 1, 1, 1, 1, 0, 0);
    step("R9 stop with byte done", 1'b1, 32'h0000_0002, 1'b0, 1, 1, 1, 1, 0, 0);
    step("R9 nack host read", 1'b0, 32'h0, 1'b0, 1, 1, 1, 0, 1, 1);
    step("R9 release", 1'b0, 32'h0, 1'b0, 1, 1, 1, 1, 0, 0);
    step("R4 switch blocked", 1'b1, 32'h0000_0010, 1'b0, 1, 1, 0, 0, 0, 0);
    step("R4 switch ok", 1'b1, 32'h0000_0010, 1'b0, 1, 1, 1, 0, 0, 0);
    wr("R4 both set", 32'h0000_0014);
    wr("R10 pec lock", 32'h0400_4000);
    wr("R8 soft reset", 32'hFFFF_FFFF);
    idle("R8 after");
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 16) != 0) d[7] = 1'b0;
      if (($urandom % 3) != 0) d[5] = 1'b0;
      if (($urandom % 3) != 0) d[3] = 1'b0;
      step("rand", ($urandom % 3) != 0, d, ($urandom % 8) == 0,
           ($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % 2,
           ($urandom % 4) == 0, ($urandom % 6) == 0, $urandom % 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule